// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block turns the output of an analog comparator into a processor interrupt. The raw comparator output is first passed through a two-flop synchronizer. It can then be inverted by a control bit. The resulting value is compared every cycle against a snapshot. Any read or any write of the comparator control register reloads that snapshot with the current value. While the two differ, the comparator flag is forced to 1 on every cycle. Software therefore has to touch the control register before a clear of the flag takes effect.

Software uses three byte registers on a simple synchronous bus:
- The control register holds the invert bit and four configuration bits, and shows the live (possibly inverted) comparator value.
- The flag register holds the comparator flag. Software clears the flag by writing 0 and can raise a software interrupt by writing 1.
- The enable register holds the local interrupt enable.

The interrupt request is registered. It asserts only when the flag, the local enable and the two externally supplied enables (peripheral and global) are all set.

Top module: `cmp_change_irq`

## Requirements
- R1: After a synchronous reset, all three registers read 0x00 and `irq` is 0.
- R2: A change of `cmp_raw` sets the flag. With all enables at 1, `irq` is still 0 three rising edges after the change and is 1 on the fourth edge (two edges of synchronizer, one edge for the flag, one edge for the request).
- R3: While the live value differs from the snapshot, writing 0 to flag bit 3 leaves the flag at 1.
- R4: A read or a write of the control register reloads the snapshot with the live value. A later write of 0 to flag bit 3 clears the flag, and the flag stays cleared.
- R5: Writing to the flag register loads bit 3 from write-data bit 3. Writing 1 sets the flag without any comparator change, and writing 0 clears it when there is no mismatch.
- R6: `irq` is a registered AND of flag bit 3, enable bit 3, `pie_en` and `glb_en`. It updates one edge after its inputs.
- R7: A mismatch sets the flag even when every enable is 0. In that case `irq` stays 0.
- R8: If the live value first changes in the same cycle in which the control register is accessed, the snapshot takes the new value and the flag is not set.
- R9: Control bit 6 reads the synchronized comparator output XOR control bit 4 (the invert bit). Writes to bit 6 are ignored.
- R10: Writable bits are: control 4:0, flag 3 and enable 3. All other bits read 0 after any write. Reads return data on `rdata` one edge after `rd_en` is sampled.
- R11: Changing the invert bit with a control write makes the live value differ from the snapshot. The flag then sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address (control 0x20, flag 0x21, enable 0x22 by default) |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, 0 when no read was sampled |
| cmp_raw | input | 1 | Asynchronous raw comparator output |
| glb_en | input | 1 | Global interrupt enable |
| pie_en | input | 1 | Peripheral interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets three corner cases:
- **Flag held by a mismatch.** Without a control access, a software clear must not stick. A design that reacts only to edges would wrongly drop the flag.
- **Coincident read.** A control read lands exactly on the cycle the synchronized value changes. A design that compares against the old snapshot without suppression would wrongly raise the flag.
- **Invert toggle.** Writing the invert bit must raise the flag. A design that snapshots the post-write value would stay silent.

Two further checks cover the request path. Eight enable combinations and the exact edge on which `irq` rises would expose a missing gate term or a wrong pipeline depth.

// File: rtl/cmpint_pkg.sv
package cmpint_pkg;
  localparam int unsigned ADDR_W_D    = 8;
  localparam int unsigned DATA_W_D    = 8;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam logic [7:0]  CTRL_ADDR_D = 8'h20;
  localparam logic [7:0]  FLAG_ADDR_D = 8'h21;
  localparam logic [7:0]  EN_ADDR_D   = 8'h22;
  localparam int unsigned OUT_BIT     = 6;
  localparam int unsigned INV_BIT     = 4;
  localparam int unsigned CFG_W       = 4;
  localparam int unsigned FLAG_BIT    = 3;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FLAG,
    SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/cmpint_sync.sv
module cmpint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpint_detect.sv
module cmpint_detect (
  input  logic clk,
  input  logic rst,
  input  logic sync_out,
  input  logic invert,
  input  logic access,
  output logic cmp_val,
  output logic mismatch,
  output logic snap_q
);
  // Live value after optional inversion.
  assign cmp_val = sync_out ^ invert;

  // Snapshot reloads on every control access with the value seen this cycle.
  always_ff @(posedge clk) begin
    if (rst)         snap_q <= 1'b0;
    else if (access) snap_q <= cmp_val;
  end

  assign mismatch = cmp_val ^ snap_q;
endmodule

// File: rtl/cmpint_regs.sv
module cmpint_regs
  import cmpint_pkg::*;
#(
  parameter int unsigned ADDR_W    = ADDR_W_D,
  parameter int unsigned DATA_W    = DATA_W_D,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_ADDR_D),
  parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_ADDR_D),
  parameter logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(EN_ADDR_D)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmp_val,
  input  logic              mismatch,
  output logic [DATA_W-1:0] rdata,
  output logic              invert,
  output logic              ctrl_acc,
  output logic              flag,
  output logic              flag_en,
  output logic              flag_wr
);
  localparam int unsigned CTRL_W = INV_BIT + 1;

  reg_sel_e          sel;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  always_comb begin
    if      (addr == CTRL_ADDR) sel = SEL_CTRL;
    else if (addr == FLAG_ADDR) sel = SEL_FLAG;
    else if (addr == EN_ADDR)   sel = SEL_EN;
    else                        sel = SEL_NONE;
  end

  assign ctrl_acc = (rd_en | wr_en) && (sel == SEL_CTRL);
  assign flag_wr  = wr_en && (sel == SEL_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      invert  <= 1'b0;
      flag_en <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) {invert, cfg_q} <= wdata[CTRL_W-1:0];
      if (wr_en && sel == SEL_EN)   flag_en <= wdata[FLAG_BIT];
      // A mismatch outside a control access overrides any software write.
      if (mismatch && !ctrl_acc) flag <= 1'b1;
      else if (flag_wr)          flag <= wdata[FLAG_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_mux[OUT_BIT]     = cmp_val;
        rd_mux[INV_BIT]     = invert;
        rd_mux[CFG_W-1:0]   = cfg_q;
      end
      SEL_FLAG: rd_mux[FLAG_BIT] = flag;
      SEL_EN:   rd_mux[FLAG_BIT] = flag_en;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];
endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmpint_pkg::*;
#(
  parameter int unsigned ADDR_W    = ADDR_W_D,
  parameter int unsigned DATA_W    = DATA_W_D,
  parameter int unsigned SYNC_N    = SYNC_DEPTH,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_ADDR_D),
  parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_ADDR_D),
  parameter logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(EN_ADDR_D)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmp_raw,
  input  logic              glb_en,
  input  logic              pie_en,
  output logic              irq
);
  logic sync_w, invert_w, ctrl_acc_w, cmp_val_w, mismatch_w, snap_w;
  logic flag_w, fen_w, flag_wr_w, flag_wbit_w;

  assign flag_wbit_w = wdata[FLAG_BIT];

  cmpint_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst(rst), .d(cmp_raw), .q(sync_w)
  );

  cmpint_detect detect_i (
    .clk(clk), .rst(rst), .sync_out(sync_w), .invert(invert_w),
    .access(ctrl_acc_w), .cmp_val(cmp_val_w), .mismatch(mismatch_w),
    .snap_q(snap_w)
  );

  cmpint_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cmp_val(cmp_val_w), .mismatch(mismatch_w),
    .rdata(rdata), .invert(invert_w), .ctrl_acc(ctrl_acc_w),
    .flag(flag_w), .flag_en(fen_w), .flag_wr(flag_wr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag_w & fen_w & pie_en & glb_en;
  end
endmodule

// File: rtl/cmp_change_irq_chk.sv
module cmp_change_irq_chk (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic flag,
  input logic fen,
  input logic pie,
  input logic gie,
  input logic mismatch,
  input logic ctrl_acc,
  input logic snap,
  input logic cmp_val,
  input logic flag_wr,
  input logic wbit
);
  // R1: reset clears the request and the flag
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!irq && !flag));

  // R6: request only when all four terms were set one edge earlier
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && fen && pie && gie));

  // R3: a mismatch outside a control access forces the flag
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !ctrl_acc) |=> flag);

  // R4: a control access reloads the snapshot with the live value
  p_snap_reload_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_acc |=> (snap == $past(cmp_val)));

  // R8: a clear flag stays clear across a control access
  p_access_no_set_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_acc && !flag) |=> !flag);

  // R5: writing 0 with no mismatch clears the flag
  p_sw_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !wbit && !mismatch) |=> !flag);
endmodule

bind cmp_change_irq cmp_change_irq_chk chk_i (
  .clk(clk), .rst(rst), .irq(irq), .flag(flag_w), .fen(fen_w),
  .pie(pie_en), .gie(glb_en), .mismatch(mismatch_w), .ctrl_acc(ctrl_acc_w),
  .snap(snap_w), .cmp_val(cmp_val_w), .flag_wr(flag_wr_w), .wbit(flag_wbit_w)
);

// File: tb/cmp_change_irq_tb_top.sv
`timescale 1ns/1ps
module cmp_change_irq_tb_top;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_FLAG = 8'h21;
  localparam logic [7:0] A_EN   = 8'h22;
  // {glb_en, pie_en, enable bit, expected irq}
  localparam logic [3:0] GATE_TBL [8] = '{4'b0000, 4'b0010, 4'b0100, 4'b0110,
                                          4'b1000, 4'b1010, 4'b1100, 4'b1111};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cmp_raw = 1'b0, glb_en = 1'b0, pie_en = 1'b0;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  cmp_change_irq dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cmp_raw(cmp_raw), .glb_en(glb_en),
    .pie_en(pie_en), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    logic [7:0] tmp;
    bus_read(A_CTRL, tmp);
    bus_write(A_FLAG, 8'h00);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    bus_read(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
    bus_read(A_FLAG, rv); chk("R1 flag", rv, 8'h00);
    bus_read(A_EN, rv);   chk("R1 en", rv, 8'h00);

    // R11 / R9 / R10: set all control bits, invert flips the live value
    bus_write(A_CTRL, 8'hFF);
    @(negedge clk);
    bus_read(A_FLAG, rv); chk("R11 flag after invert", rv, 8'h08);
    bus_read(A_CTRL, rv); chk("R9 R10 ctrl readback", rv, 8'h5F);
    bus_write(A_FLAG, 8'h00);
    bus_read(A_FLAG, rv); chk("R4 clear after read", rv, 8'h00);
    bus_write(A_FLAG, 8'hFF);
    bus_read(A_FLAG, rv); chk("R5 R10 flag set by write", rv, 8'h08);
    bus_write(A_EN, 8'hFF);
    bus_read(A_EN, rv);   chk("R10 enable readback", rv, 8'h08);
    bus_write(A_FLAG, 8'h00);
    bus_read(A_FLAG, rv); chk("R5 flag clear by write", rv, 8'h00);
    bus_write(A_CTRL, 8'h00);
    settle();
    bus_write(A_EN, 8'h00);
    bus_read(A_CTRL, rv); chk("R9 ctrl back to zero", rv, 8'h00);

    // R6 enable gating table with a software-set flag
    bus_write(A_FLAG, 8'h08);
    for (int i = 0; i < 8; i++) begin
      glb_en = GATE_TBL[i][3];
      pie_en = GATE_TBL[i][2];
      bus_write(A_EN, {4'b0, GATE_TBL[i][1], 3'b0});
      @(negedge clk);
      chk($sformatf("R6 gate row %0d", i), {7'b0, irq}, {7'b0, GATE_TBL[i][0]});
    end
    glb_en = 1'b0; pie_en = 1'b0;
    bus_write(A_EN, 8'h00);
    bus_write(A_FLAG, 8'h00);

    // R7 flag sets with all enables off
    @(negedge clk); cmp_raw = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_FLAG, rv); chk("R7 flag without enables", rv, 8'h08);
    chk("R7 irq stays low", {7'b0, irq}, 8'h00);

    // R3 software clear does not stick without a control access
    bus_write(A_FLAG, 8'h00);
    bus_read(A_FLAG, rv); chk("R3 flag held by mismatch", rv, 8'h08);

    // R4 read reloads the snapshot
    bus_read(A_CTRL, rv); chk("R9 live value high", rv, 8'h40);
    bus_write(A_FLAG, 8'h00);
    repeat (3) @(negedge clk);
    bus_read(A_FLAG, rv); chk("R4 clear sticks after read", rv, 8'h00);

    // R4 write reloads the snapshot
    @(negedge clk); cmp_raw = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(A_CTRL, 8'h00);
    bus_write(A_FLAG, 8'h00);
    repeat (3) @(negedge clk);
    bus_read(A_FLAG, rv); chk("R4 clear sticks after write", rv, 8'h00);

    // R2 exact edge of the request
    glb_en = 1'b1; pie_en = 1'b1;
    bus_write(A_EN, 8'h08);
    @(negedge clk); cmp_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 irq low after three edges", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R2 irq high on fourth edge", {7'b0, irq}, 8'h01);
    settle();
    @(negedge clk);
    chk("R6 irq drops after clear", {7'b0, irq}, 8'h00);

    // R8 change coinciding with a control read
    @(negedge clk); cmp_raw = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = A_CTRL; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R8 read shows new value", rdata, 8'h00);
    repeat (4) @(negedge clk);
    chk("R8 no irq", {7'b0, irq}, 8'h00);
    bus_read(A_FLAG, rv); chk("R8 flag not set", rv, 8'h00);

    finish_run();
  end
endmodule